// File: doc/BRIEF.md
# Sixteen-bit instruction word decoder

This block is a purely combinational decoder for one 16-bit instruction word of a compact 8-bit microcontroller instruction set. It looks at the word once and produces an operation code plus every operand field the execution stage needs: destination register index, source register index, 8-bit immediate, I/O address, bit index and register-pair selector. A single flag reports a word that matches none of the supported patterns.

The supported classes are two-register arithmetic and logic, byte-immediate arithmetic and logic on the upper register bank, single-register operations, stack push and pop, I/O port read and write, I/O bit set and clear, and word add/subtract of a small immediate on one of four register pairs. Several operand fields are scattered across the word (split register index bits, split immediates, split I/O addresses) and are reassembled here. One encoding is aliased: an add whose two register fields name the same register is reported as a logical shift left of that register.

The decoder is split into four class decoders whose results are merged. A parameter removes the multiply encoding for cores that have no multiplier.

Top module: `insn_word_decoder`

## Requirements
- R1: The operation code output uses these values: 0 none, 1 add, 2 add with carry, 3 subtract, 4 subtract with carry, 5 and, 6 exclusive or, 7 or, 8 multiply, 9 shift left, 10 subtract immediate, 11 subtract immediate with carry, 12 and immediate, 13 or immediate, 14 complement, 15 nibble swap, 16 increment, 17 arithmetic shift right, 18 logical shift right, 19 decrement, 20 push, 21 pop, 22 port read, 23 port write, 24 I/O bit clear, 25 I/O bit set, 26 word add immediate, 27 word subtract immediate.
- R2: For two-register words, bits 15:10 select the operation (000011 add, 000111 add with carry, 000110 subtract, 000010 subtract with carry, 001000 and, 001001 exclusive or, 001010 or, 100111 multiply); destination is bits 8:4 and source is bit 9 concatenated with bits 3:0.
- R3: An add-pattern word whose destination and source fields are equal decodes as shift left (code 9) with both register outputs equal to that register; other two-register patterns with equal fields keep their own code.
- R4: Bits 15:12 of 0101, 0100, 0111, 0110 select subtract immediate, subtract immediate with carry, and immediate, or immediate; the immediate is bits 11:8 as high nibble and bits 3:0 as low nibble, and the destination is 16 plus bits 7:4.
- R5: Words with bits 15:9 equal to 1001010 are single-register operations with destination bits 8:4, the low nibble choosing complement (0x0), swap (0x2), increment (0x3), arithmetic shift right (0x5), logical shift right (0x6) or decrement (0xA); any other low nibble is illegal.
- R6: Bits 15:9 of 1001001 with low nibble 0xF is push of source bits 8:4; bits 15:9 of 1001000 with low nibble 0xF is pop into destination bits 8:4; other low nibbles in these groups are illegal.
- R7: Bits 15:12 of 1011 is a port access: bit 11 clear is a read into destination bits 8:4, bit 11 set is a write from source bits 8:4, and the 6-bit I/O address is bits 10:9 above bits 3:0.
- R8: Bits 15:8 of 0x98 clear an I/O bit and 0x9A set one; the I/O address is bits 7:3 zero-extended to 6 bits and the bit index is bits 2:0; 0x99 and 0x9B are illegal.
- R9: Bits 15:8 of 0x96 is word add immediate and 0x97 word subtract immediate; the pair selector is bits 5:4, the destination is the even register 24 plus twice the selector, and the immediate is bits 7:6 above bits 3:0, zero-extended.
- R10: Every operand output not used by the decoded operation reads zero.
- R11: A word matching no pattern above raises the illegal flag, gives operation code 0 and drives every operand output to zero; legal words keep the flag low.
- R12: With the multiply parameter disabled, the multiply pattern is illegal while all other patterns decode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 16 | Instruction word to decode |
| op_code | output | 5 | Decoded operation code (R1 values) |
| dst_reg | output | 5 | Destination register index |
| src_reg | output | 5 | Source register index |
| imm_val | output | 8 | Reassembled immediate |
| io_addr | output | 6 | Reassembled I/O address |
| bit_idx | output | 3 | Bit index for I/O bit operations |
| pair_sel | output | 2 | Register-pair selector for word operations |
| illegal | output | 1 | Word matches no supported pattern |

## Verification
The bench builds two copies side by side: one with the default parameters (multiplier present, upper bank at 16, pairs from 24) and one with the multiplier disabled. The default copy reaches every operation class, the equal-register shift alias and the extreme field values such as register 31, address 63 and immediate 0xFF; the second copy is the only way to reach the multiply pattern falling through to illegal while its neighbours still decode. Both copies see the same words, so a difference between them outside the multiply pattern would be reported.

// File: rtl/iwd_pkg.sv
package iwd_pkg;

  localparam int WORD_W = 16;
  localparam int RIDX_W = 5;
  localparam int IMM_W  = 8;
  localparam int IOA_W  = 6;
  localparam int BITN_W = 3;
  localparam int PAIR_W = 2;
  localparam int OPC_W  = 5;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 5'd0,
    OP_ADD   = 5'd1,
    OP_ADC   = 5'd2,
    OP_SUB   = 5'd3,
    OP_SBC   = 5'd4,
    OP_AND   = 5'd5,
    OP_EOR   = 5'd6,
    OP_OR    = 5'd7,
    OP_MUL   = 5'd8,
    OP_LSL   = 5'd9,
    OP_SUBI  = 5'd10,
    OP_SBCI  = 5'd11,
    OP_ANDI  = 5'd12,
    OP_ORI   = 5'd13,
    OP_COM   = 5'd14,
    OP_SWAP  = 5'd15,
    OP_INC   = 5'd16,
    OP_ASR   = 5'd17,
    OP_LSR   = 5'd18,
    OP_DEC   = 5'd19,
    OP_PUSH  = 5'd20,
    OP_POP   = 5'd21,
    OP_PRD   = 5'd22,
    OP_PWR   = 5'd23,
    OP_IOCLR = 5'd24,
    OP_IOSET = 5'd25,
    OP_ADDW  = 5'd26,
    OP_SUBW  = 5'd27
  } op_e;

  typedef struct packed {
    op_e                op;
    logic [RIDX_W-1:0]  dst;
    logic [RIDX_W-1:0]  src;
    logic [IMM_W-1:0]   imm;
    logic [IOA_W-1:0]   io;
    logic [BITN_W-1:0]  bitn;
    logic [PAIR_W-1:0]  pair;
  } dec_t;

  // two-register class selectors (bits 15:10)
  localparam logic [5:0] PFX_ADD = 6'b000011;
  localparam logic [5:0] PFX_ADC = 6'b000111;
  localparam logic [5:0] PFX_SUB = 6'b000110;
  localparam logic [5:0] PFX_SBC = 6'b000010;
  localparam logic [5:0] PFX_AND = 6'b001000;
  localparam logic [5:0] PFX_EOR = 6'b001001;
  localparam logic [5:0] PFX_OR  = 6'b001010;
  localparam logic [5:0] PFX_MUL = 6'b100111;

  // byte-immediate class selectors (bits 15:12)
  localparam logic [3:0] TOP_SUBI = 4'b0101;
  localparam logic [3:0] TOP_SBCI = 4'b0100;
  localparam logic [3:0] TOP_ANDI = 4'b0111;
  localparam logic [3:0] TOP_ORI  = 4'b0110;

  // single-register group and its low-nibble selectors
  localparam logic [6:0] GRP_UNARY = 7'b1001010;
  localparam logic [6:0] GRP_PUSH  = 7'b1001001;
  localparam logic [6:0] GRP_POP   = 7'b1001000;
  localparam logic [3:0] LO_COM    = 4'h0;
  localparam logic [3:0] LO_SWAP   = 4'h2;
  localparam logic [3:0] LO_INC    = 4'h3;
  localparam logic [3:0] LO_ASR    = 4'h5;
  localparam logic [3:0] LO_LSR    = 4'h6;
  localparam logic [3:0] LO_DEC    = 4'hA;
  localparam logic [3:0] LO_STACK  = 4'hF;

  localparam logic [7:0] HI_IOCLR = 8'h98;
  localparam logic [7:0] HI_IOSET = 8'h9A;
  localparam logic [7:0] HI_ADDW  = 8'h96;
  localparam logic [7:0] HI_SUBW  = 8'h97;
  localparam logic [3:0] GRP_PORT = 4'b1011;

  // ---- field extraction helpers ----
  function automatic logic [RIDX_W-1:0] fld_mid_reg(input logic [WORD_W-1:0] w);
    return w[8:4];
  endfunction

  function automatic logic [RIDX_W-1:0] fld_split_reg(input logic [WORD_W-1:0] w);
    return {w[9], w[3:0]};
  endfunction

  function automatic logic [IMM_W-1:0] fld_kbyte(input logic [WORD_W-1:0] w);
    return {w[11:8], w[3:0]};
  endfunction

  function automatic logic [RIDX_W-1:0] fld_high_reg(input logic [WORD_W-1:0] w,
                                                      input logic [RIDX_W-1:0] base);
    return base + RIDX_W'(w[7:4]);
  endfunction

  function automatic logic [IOA_W-1:0] fld_port_addr(input logic [WORD_W-1:0] w);
    return {w[10:9], w[3:0]};
  endfunction

  function automatic logic [IOA_W-1:0] fld_bitio_addr(input logic [WORD_W-1:0] w);
    return IOA_W'(w[7:3]);
  endfunction

  function automatic logic [BITN_W-1:0] fld_bitn(input logic [WORD_W-1:0] w);
    return w[2:0];
  endfunction

  function automatic logic [IMM_W-1:0] fld_wimm(input logic [WORD_W-1:0] w);
    return IMM_W'({w[7:6], w[3:0]});
  endfunction

  function automatic logic [PAIR_W-1:0] fld_pair(input logic [WORD_W-1:0] w);
    return w[5:4];
  endfunction

  function automatic logic [RIDX_W-1:0] pair_reg(input logic [PAIR_W-1:0] p,
                                                  input logic [RIDX_W-1:0] base);
    return base + RIDX_W'({p, 1'b0});
  endfunction

endpackage

// File: rtl/iwd_twoop_dec.sv
module iwd_twoop_dec
  import iwd_pkg::*;
#(
  parameter bit HAS_MUL = 1'b1
) (
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output logic              shift_alias,
  output dec_t              fields
);

  localparam int PFX_W = 6;

  logic [PFX_W-1:0]  pfx;
  logic [RIDX_W-1:0] rd;
  logic [RIDX_W-1:0] rr;
  logic              mul_hit;
  logic              same_reg;

  assign pfx      = word[WORD_W-1 -: PFX_W];
  assign rd       = fld_mid_reg(word);
  assign rr       = fld_split_reg(word);
  assign same_reg = (rd == rr);

  generate
    if (HAS_MUL) begin : g_mul
      assign mul_hit = (pfx == PFX_MUL);
    end else begin : g_nomul
      assign mul_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    fields      = '0;
    hit         = 1'b1;
    shift_alias = 1'b0;
    case (pfx)
      PFX_ADD: begin
        if (same_reg) begin
          fields.op   = OP_LSL;
          shift_alias = 1'b1;
        end else begin
          fields.op   = OP_ADD;
        end
      end
      PFX_ADC: fields.op = OP_ADC;
      PFX_SUB: fields.op = OP_SUB;
      PFX_SBC: fields.op = OP_SBC;
      PFX_AND: fields.op = OP_AND;
      PFX_EOR: fields.op = OP_EOR;
      PFX_OR:  fields.op = OP_OR;
      default: begin
        if (mul_hit) fields.op = OP_MUL;
        else         hit       = 1'b0;
      end
    endcase
    if (hit) begin
      fields.dst = rd;
      fields.src = rr;
    end
  end

endmodule

// File: rtl/iwd_immop_dec.sv
module iwd_immop_dec
  import iwd_pkg::*;
#(
  parameter int HIGH_REG_BASE = 16
) (
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output dec_t              fields
);

  localparam logic [RIDX_W-1:0] HB = RIDX_W'(HIGH_REG_BASE);

  logic [3:0] top;
  assign top = word[WORD_W-1 -: 4];

  always_comb begin
    fields = '0;
    hit    = 1'b1;
    case (top)
      TOP_SUBI: fields.op = OP_SUBI;
      TOP_SBCI: fields.op = OP_SBCI;
      TOP_ANDI: fields.op = OP_ANDI;
      TOP_ORI:  fields.op = OP_ORI;
      default:  hit       = 1'b0;
    endcase
    if (hit) begin
      fields.dst = fld_high_reg(word, HB);
      fields.imm = fld_kbyte(word);
    end
  end

endmodule

// File: rtl/iwd_misc_dec.sv
module iwd_misc_dec
  import iwd_pkg::*;
#(
  parameter int PAIR_REG_BASE = 24
) (
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output dec_t              fields
);

  localparam logic [RIDX_W-1:0] PB = RIDX_W'(PAIR_REG_BASE);

  logic [6:0] hi7;
  logic [7:0] hi8;
  logic [3:0] lo4;

  assign hi7 = word[WORD_W-1 -: 7];
  assign hi8 = word[WORD_W-1 -: 8];
  assign lo4 = word[3:0];

  always_comb begin
    fields = '0;
    hit    = 1'b0;
    if (hi7 == GRP_UNARY) begin
      hit = 1'b1;
      case (lo4)
        LO_COM:  fields.op = OP_COM;
        LO_SWAP: fields.op = OP_SWAP;
        LO_INC:  fields.op = OP_INC;
        LO_ASR:  fields.op = OP_ASR;
        LO_LSR:  fields.op = OP_LSR;
        LO_DEC:  fields.op = OP_DEC;
        default: hit       = 1'b0;
      endcase
      if (hit) fields.dst = fld_mid_reg(word);
    end else if (hi7 == GRP_PUSH && lo4 == LO_STACK) begin
      hit        = 1'b1;
      fields.op  = OP_PUSH;
      fields.src = fld_mid_reg(word);
    end else if (hi7 == GRP_POP && lo4 == LO_STACK) begin
      hit        = 1'b1;
      fields.op  = OP_POP;
      fields.dst = fld_mid_reg(word);
    end else if (hi8 == HI_IOCLR || hi8 == HI_IOSET) begin
      hit         = 1'b1;
      fields.op   = (hi8 == HI_IOSET) ? OP_IOSET : OP_IOCLR;
      fields.io   = fld_bitio_addr(word);
      fields.bitn = fld_bitn(word);
    end else if (hi8 == HI_ADDW || hi8 == HI_SUBW) begin
      hit         = 1'b1;
      fields.op   = (hi8 == HI_SUBW) ? OP_SUBW : OP_ADDW;
      fields.pair = fld_pair(word);
      fields.dst  = pair_reg(fld_pair(word), PB);
      fields.imm  = fld_wimm(word);
    end
  end

endmodule

// File: rtl/iwd_port_dec.sv
module iwd_port_dec
  import iwd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output dec_t              fields
);

  logic is_write;
  assign is_write = word[11];

  always_comb begin
    fields = '0;
    hit    = (word[WORD_W-1 -: 4] == GRP_PORT);
    if (hit) begin
      fields.io = fld_port_addr(word);
      if (is_write) begin
        fields.op  = OP_PWR;
        fields.src = fld_mid_reg(word);
      end else begin
        fields.op  = OP_PRD;
        fields.dst = fld_mid_reg(word);
      end
    end
  end

endmodule

// File: rtl/insn_word_decoder.sv
module insn_word_decoder
  import iwd_pkg::*;
#(
  parameter bit HAS_MUL       = 1'b1,
  parameter int HIGH_REG_BASE = 16,
  parameter int PAIR_REG_BASE = 24
) (
  input  logic [15:0] instr_word,
  output logic [4:0]  op_code,
  output logic [4:0]  dst_reg,
  output logic [4:0]  src_reg,
  output logic [7:0]  imm_val,
  output logic [5:0]  io_addr,
  output logic [2:0]  bit_idx,
  output logic [1:0]  pair_sel,
  output logic        illegal
);

  localparam int N_GRP    = 4;
  localparam int G_TWOOP  = 0;
  localparam int G_IMMOP  = 1;
  localparam int G_MISC   = 2;
  localparam int G_PORT   = 3;

  logic [N_GRP-1:0] grp_hit;
  dec_t             grp_fld [N_GRP];
  logic             lsl_alias;
  dec_t             merged;

  iwd_twoop_dec #(.HAS_MUL(HAS_MUL)) u_twoop (
    .word        (instr_word),
    .hit         (grp_hit[G_TWOOP]),
    .shift_alias (lsl_alias),
    .fields      (grp_fld[G_TWOOP])
  );

  iwd_immop_dec #(.HIGH_REG_BASE(HIGH_REG_BASE)) u_immop (
    .word   (instr_word),
    .hit    (grp_hit[G_IMMOP]),
    .fields (grp_fld[G_IMMOP])
  );

  iwd_misc_dec #(.PAIR_REG_BASE(PAIR_REG_BASE)) u_misc (
    .word   (instr_word),
    .hit    (grp_hit[G_MISC]),
    .fields (grp_fld[G_MISC])
  );

  iwd_port_dec u_port (
    .word   (instr_word),
    .hit    (grp_hit[G_PORT]),
    .fields (grp_fld[G_PORT])
  );

  // class patterns are disjoint, so an OR of the gated group results is the merge
  always_comb begin
    merged = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (grp_hit[g]) merged = dec_t'(merged | grp_fld[g]);
    end
  end

  assign illegal  = ~|grp_hit;
  assign op_code  = merged.op;
  assign dst_reg  = merged.dst;
  assign src_reg  = merged.src;
  assign imm_val  = merged.imm;
  assign io_addr  = merged.io;
  assign bit_idx  = merged.bitn;
  assign pair_sel = merged.pair;

endmodule

// File: rtl/iwd_checker.sv
module iwd_checker
  import iwd_pkg::*;
(
  input logic [15:0] instr_word,
  input logic [4:0]  op_code,
  input logic [4:0]  dst_reg,
  input logic [4:0]  src_reg,
  input logic [7:0]  imm_val,
  input logic [5:0]  io_addr,
  input logic [2:0]  bit_idx,
  input logic [1:0]  pair_sel,
  input logic        illegal,
  input logic [3:0]  grp_hit,
  input logic        lsl_alias
);

  logic known;
  assign known = !$isunknown(instr_word);

  always_comb begin
    if (known) begin
      // R11
      one_class_chk: assert ($onehot0(grp_hit));
      // R11
      illegal_blank_chk: assert (!illegal || (op_code == 5'd0 && dst_reg == 5'd0 &&
                                  src_reg == 5'd0 && imm_val == 8'd0 && io_addr == 6'd0 &&
                                  bit_idx == 3'd0 && pair_sel == 2'd0));
      // R3
      shift_alias_chk: assert (!lsl_alias || (op_code == OP_LSL && dst_reg == src_reg));
      // R3
      add_distinct_chk: assert (op_code != OP_ADD || dst_reg != src_reg);
      // R4
      imm_upper_bank_chk: assert (!(op_code >= OP_SUBI && op_code <= OP_ORI) ||
                                   (dst_reg[4] && src_reg == 5'd0));
      // R9
      pair_even_chk: assert (!(op_code == OP_ADDW || op_code == OP_SUBW) ||
                              (dst_reg[0] == 1'b0 && dst_reg[2:1] == pair_sel &&
                               imm_val[7:6] == 2'b00));
      // R8
      bitio_range_chk: assert (!(op_code == OP_IOCLR || op_code == OP_IOSET) ||
                                (io_addr[5] == 1'b0 && dst_reg == 5'd0 && src_reg == 5'd0));
      // R10
      unary_unused_chk: assert (!(op_code >= OP_COM && op_code <= OP_DEC) ||
                                 (src_reg == 5'd0 && imm_val == 8'd0 && io_addr == 6'd0));
    end
  end

endmodule

bind insn_word_decoder iwd_checker u_iwd_chk (
  .instr_word (instr_word),
  .op_code    (op_code),
  .dst_reg    (dst_reg),
  .src_reg    (src_reg),
  .imm_val    (imm_val),
  .io_addr    (io_addr),
  .bit_idx    (bit_idx),
  .pair_sel   (pair_sel),
  .illegal    (illegal),
  .grp_hit    (grp_hit),
  .lsl_alias  (lsl_alias)
);

// File: tb/insn_word_decoder_bench.sv
module insn_word_decoder_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] instr = 16'h0000;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [4:0] m_op, m_dst, m_src, n_op, n_dst, n_src;
  logic [7:0] m_imm, n_imm;
  logic [5:0] m_io, n_io;
  logic [2:0] m_bit, n_bit;
  logic [1:0] m_pair, n_pair;
  logic       m_ill, n_ill;

  insn_word_decoder u_insn_word_decoder (
    .instr_word(instr), .op_code(m_op), .dst_reg(m_dst), .src_reg(m_src),
    .imm_val(m_imm), .io_addr(m_io), .bit_idx(m_bit), .pair_sel(m_pair), .illegal(m_ill)
  );

  insn_word_decoder #(.HAS_MUL(1'b0)) u_nomul (
    .instr_word(instr), .op_code(n_op), .dst_reg(n_dst), .src_reg(n_src),
    .imm_val(n_imm), .io_addr(n_io), .bit_idx(n_bit), .pair_sel(n_pair), .illegal(n_ill)
  );

  wire [34:0] got_m = {m_op, m_dst, m_src, m_imm, m_io, m_bit, m_pair, m_ill};
  wire [34:0] got_n = {n_op, n_dst, n_src, n_imm, n_io, n_bit, n_pair, n_ill};

  // expected-value packing: op, dst, src, imm, io, bit, pair, illegal
  function automatic logic [34:0] pk(input int op, input int dst, input int src, input int imm,
                                     input int io, input int bn, input int pr, input bit ill);
    return {op[4:0], dst[4:0], src[4:0], imm[7:0], io[5:0], bn[2:0], pr[1:0], ill};
  endfunction

  localparam logic [34:0] EXP_BAD = {5'd0, 5'd0, 5'd0, 8'd0, 6'd0, 3'd0, 2'd0, 1'b1};

  task automatic drive(input logic [15:0] w);
    @(negedge clk);
    instr = w;
    #2;
  endtask

  task automatic cmp(input string tag, input string who, input logic [34:0] got,
                     input logic [34:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s (%s) word=%h actual=%h expected=%h", tag, who, instr, got, exp);
    end
  endtask

  task automatic expect_both(input string tag, input logic [15:0] w, input logic [34:0] exp);
    drive(w);
    cmp(tag, "default", got_m, exp);
    cmp(tag, "no-mul", got_n, exp);
  endtask

  // word builders
  function automatic logic [15:0] enc_rr(input logic [5:0] p, input logic [4:0] d, input logic [4:0] r);
    return {p, r[4], d, r[3:0]};
  endfunction
  function automatic logic [15:0] enc_imm(input logic [3:0] t, input logic [7:0] k, input logic [3:0] d);
    return {t, k[7:4], d, k[3:0]};
  endfunction

  task automatic t_reset_state;
    // R11: all-zero word after reset is not a supported pattern
    expect_both("R11 reset", 16'h0000, EXP_BAD);
  endtask

  task automatic t_two_reg;
    logic [5:0] pf [8] = '{6'b000011, 6'b000111, 6'b000110, 6'b000010,
                           6'b001000, 6'b001001, 6'b001010, 6'b100111};
    for (int i = 0; i < 7; i++) begin
      int d = (i * 5 + 3) % 32;
      int r = (i * 7 + 20) % 32;
      // R1 R2 R10
      expect_both("R2 two-reg", enc_rr(pf[i], d[4:0], r[4:0]), pk(i + 1, d, r, 0, 0, 0, 0, 0));
    end
    expect_both("R2 add 31,0", enc_rr(pf[0], 5'd31, 5'd0), pk(1, 31, 0, 0, 0, 0, 0, 0));
    expect_both("R2 or 0,31", enc_rr(pf[6], 5'd0, 5'd31), pk(7, 0, 31, 0, 0, 0, 0, 0));
    drive(enc_rr(pf[7], 5'd6, 5'd5));
    cmp("R2 mul", "default", got_m, pk(8, 6, 5, 0, 0, 0, 0, 0));
    // R12: multiply pattern illegal without the multiplier
    cmp("R12 mul removed", "no-mul", got_n, EXP_BAD);
    drive(enc_rr(pf[7], 5'd31, 5'd31));
    cmp("R12 mul removed 31", "no-mul", got_n, EXP_BAD);
  endtask

  task automatic t_lsl_alias;
    int regs [3] = '{0, 17, 31};
    for (int i = 0; i < 3; i++) begin
      // R3
      expect_both("R3 shift alias", enc_rr(6'b000011, regs[i][4:0], regs[i][4:0]),
                  pk(9, regs[i], regs[i], 0, 0, 0, 0, 0));
    end
    expect_both("R3 adc same reg", enc_rr(6'b000111, 5'd9, 5'd9), pk(2, 9, 9, 0, 0, 0, 0, 0));
    expect_both("R3 eor same reg", enc_rr(6'b001001, 5'd20, 5'd20), pk(6, 20, 20, 0, 0, 0, 0, 0));
  endtask

  task automatic t_imm_ops;
    logic [3:0] tp [4] = '{4'b0101, 4'b0100, 4'b0111, 4'b0110};
    logic [7:0] ks [3] = '{8'h00, 8'hFF, 8'hA5};
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 3; j++) begin
        int d = (i * 4 + j * 5) % 16;
        // R4
        expect_both("R4 byte immediate", enc_imm(tp[i], ks[j], d[3:0]),
                    pk(10 + i, 16 + d, 0, ks[j], 0, 0, 0, 0));
      end
    end
    expect_both("R4 reg 31", enc_imm(4'b0110, 8'h3C, 4'hF), pk(13, 31, 0, 8'h3C, 0, 0, 0, 0));
  endtask

  task automatic t_single;
    for (int n = 0; n < 16; n++) begin
      int op;
      int d = (n * 3 + 1) % 32;
      case (n)
        0: op = 14; 2: op = 15; 3: op = 16; 5: op = 17; 6: op = 18; 10: op = 19;
        default: op = 0;
      endcase
      if (op != 0)
        // R5 R10
        expect_both("R5 single-reg", {7'b1001010, d[4:0], n[3:0]}, pk(op, d, 0, 0, 0, 0, 0, 0));
      else
        // R5 R11: unlisted low nibble
        expect_both("R5 unlisted nibble", {7'b1001010, d[4:0], n[3:0]}, EXP_BAD);
    end
    expect_both("R5 dec r31", {7'b1001010, 5'd31, 4'hA}, pk(19, 31, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_stack;
    // R6
    expect_both("R6 push", {7'b1001001, 5'd22, 4'hF}, pk(20, 0, 22, 0, 0, 0, 0, 0));
    expect_both("R6 push r31", {7'b1001001, 5'd31, 4'hF}, pk(20, 0, 31, 0, 0, 0, 0, 0));
    expect_both("R6 pop", {7'b1001000, 5'd13, 4'hF}, pk(21, 13, 0, 0, 0, 0, 0, 0));
    expect_both("R6 push bad nibble", {7'b1001001, 5'd4, 4'h0}, EXP_BAD);
    expect_both("R6 pop bad nibble", {7'b1001000, 5'd4, 4'h7}, EXP_BAD);
  endtask

  task automatic t_port;
    int addrs [3] = '{0, 63, 42};
    for (int i = 0; i < 3; i++) begin
      logic [5:0] a = addrs[i][5:0];
      int d = 31 - i * 11;
      // R7
      expect_both("R7 port read", {5'b10110, a[5:4], d[4:0], a[3:0]}, pk(22, d, 0, 0, a, 0, 0, 0));
      expect_both("R7 port write", {5'b10111, a[5:4], d[4:0], a[3:0]}, pk(23, 0, d, 0, a, 0, 0, 0));
    end
  endtask

  task automatic t_bitio;
    // R8
    expect_both("R8 bit clear", {8'h98, 5'd31, 3'd7}, pk(24, 0, 0, 0, 31, 7, 0, 0));
    expect_both("R8 bit set", {8'h9A, 5'd0, 3'd0}, pk(25, 0, 0, 0, 0, 0, 0, 0));
    expect_both("R8 bit set mid", {8'h9A, 5'd19, 3'd5}, pk(25, 0, 0, 0, 19, 5, 0, 0));
    expect_both("R8 neighbour 0x99", {8'h99, 5'd3, 3'd1}, EXP_BAD);
    expect_both("R8 neighbour 0x9B", {8'h9B, 5'd3, 3'd1}, EXP_BAD);
  endtask

  task automatic t_word;
    for (int p = 0; p < 4; p++) begin
      int k = (p * 21 + 5) % 64;
      logic [5:0] kk = k[5:0];
      // R9
      expect_both("R9 word add", {8'h96, kk[5:4], p[1:0], kk[3:0]}, pk(26, 24 + 2 * p, 0, k, 0, 0, p, 0));
      expect_both("R9 word sub", {8'h97, 2'b11, p[1:0], 4'hF}, pk(27, 24 + 2 * p, 0, 63, 0, 0, p, 0));
    end
  endtask

  task automatic t_illegal;
    logic [15:0] ws [6] = '{16'hFFFF, 16'hC123, 16'h8000, 16'h0400, 16'h2C00, 16'hF0F0};
    for (int i = 0; i < 6; i++) begin
      // R11
      expect_both("R11 unmatched", ws[i], EXP_BAD);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_two_reg();
    t_lsl_alias();
    t_imm_ops();
    t_single();
    t_stack();
    t_port();
    t_bitio();
    t_word();
    t_illegal();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

endmodule